// File: doc/BRIEF.md
# External Code Fetch Sequencer

This block runs instruction-byte fetches over a multiplexed 8-bit external program bus. Every memory cycle lasts four system clocks. In the first clock the sequencer pulses the address latch strobe and drives the low address byte on the shared port. In the second clock it releases that port. In the last two clocks it holds the active-low read strobe so that the external memory can drive the code byte, and the sequencer samples that byte on the closing edge. The high address byte sits on its own port. The sequencer reloads that port when a fetch moves to a different 256-byte page, and always on the first fetch after reset.

A simplified core hands over one instruction at a time on a valid/ready start channel. Each start carries the instruction address, its byte count and its cycle count, plus a flag for the one extra cycle needed when the instruction works on a special register. The block fetches the instruction bytes in order and returns each one on the code output. When execution needs more memory cycles than the instruction has bytes, it fills the gap with dummy fetches. At the end it pulses a done signal and only then accepts the next instruction. The start channel is back-pressured through `start_ready`, which is high only while the block is idle. The code output has no ready signal, because the bus cycle has fixed timing, so the receiver must take every beat in the clock in which `code_valid` is high.

Top module: `ext_code_fetcher`

## Requirements
- R1: Each memory cycle is four clocks long. In clock 0 `ale` is high. In clock 1 `ale` is low and `rd_n` is high. In clocks 2 and 3 `rd_n` is low. `ale` is high for exactly one clock per memory cycle.
- R2: `ad_oe` is high only in clock 0 of a memory cycle, and `ad_out` then carries bits 7:0 of the fetch address. `ad_oe` is low while `rd_n` is low and while the block is idle.
- R3: `ad_in` is sampled on the edge that ends clock 3. For a real fetch, `code_valid` is high for exactly the next clock, with the sampled value on `code_byte`. Back-pressure is not possible.
- R4: From clock 0 of each memory cycle, `hi_addr` equals bits 15:8 of the fetch address. `hi_update` is high in clock 0 whenever the port is given a new value. This happens always on the first fetch after reset, and after that only when the page differs from the previous fetch.
- R5: An instruction with byte count B and cycle count C runs max(B,C)+E memory cycles back to back, where E is `extra_cycle` and a byte count of 0 is treated as 1.
- R6: The first B cycles fetch `start_pc`, `start_pc`+1, and so on (modulo 2^16), and each of them produces one `code_valid` beat.
- R7: The remaining cycles are dummy fetches at address `start_pc`+B. They use the full strobe sequence but give no `code_valid` beat.
- R8: `instr_done` is a one-clock pulse in the clock after the final memory cycle. `start_ready` is low from the accepting edge until that clock. Starts offered while `start_ready` is low have no effect.
- R9: After reset, `ale`=0, `rd_n`=1, `ad_oe`=0, `start_ready`=1, `code_valid`=0, `instr_done`=0 and `hi_update`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Instruction start offered |
| start_ready | output | 1 | Block idle, start can be taken |
| start_pc | input | 16 | Address of the instruction's first byte |
| byte_count | input | 2 | Instruction length in bytes (0 treated as 1) |
| cycle_count | input | 3 | Memory cycles the instruction executes in |
| extra_cycle | input | 1 | Add one memory cycle (special-register operand) |
| code_valid | output | 1 | Fetched byte present for this clock |
| code_byte | output | 8 | Fetched code byte |
| instr_done | output | 1 | Pulse after the last memory cycle |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Program read strobe, active low |
| hi_addr | output | 8 | High address byte port |
| hi_update | output | 1 | High address port given a new value this cycle |
| ad_out | output | 8 | Low address drive on the shared port |
| ad_oe | output | 1 | Output enable for the shared port |
| ad_in | input | 8 | Data read from the shared port |

## Verification
Counting from the accepting edge, clock k (k = 0 .. 4T-1) is phase k mod 4 of memory cycle k/4. The strobes, port enable, low and high address bytes and `hi_update` are due in that same clock. The byte of cycle c is due on `code_valid`/`code_byte` in clock 4(c+1), and `instr_done` is due in clock 4T. The bench waits for each accepting edge, steps one falling edge per clock, and compares every output in that clock with the value a bench function predicts. The bench also keeps `ad_in` random outside clocks 2 and 3, so a byte sampled on any other edge gives a wrong value.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  // Role of one system clock inside a memory cycle
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,  // address out, latch strobe high
    PH_FLOAT = 2'd1,  // port released, no strobe
    PH_READ  = 2'd2   // read strobe active
  } ph_role_e;

  function automatic ph_role_e role_of(input int unsigned ph);
    if (ph == 0)      return PH_ADDR;
    else if (ph == 1) return PH_FLOAT;
    else              return PH_READ;
  endfunction
endpackage

// File: rtl/xfs_phase_gen.sv
module xfs_phase_gen
  import xfs_pkg::*;
#(
  parameter int CLKS = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  output ph_role_e role,
  output logic     cyc_end
);
  localparam int PW = (CLKS > 1) ? $clog2(CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)   phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                  phase <= phase + 1'b1;
  end

  assign role    = role_of(int'(phase));
  assign cyc_end = run && (phase == LAST);
endmodule

// File: rtl/xfs_cycle_ctrl.sv
module xfs_cycle_ctrl #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [BYTE_W-1:0] byte_count,
  input  logic [CNT_W-1:0]  cycle_count,
  input  logic              extra_cycle,
  input  logic              cyc_end,
  output logic              busy,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              real_fetch,
  output logic              last_cycle,
  output logic [ADDR_W-1:0] next_addr,
  output logic              done
);
  localparam int TOT_W = ((CNT_W > BYTE_W) ? CNT_W : BYTE_W) + 1;

  logic [TOT_W-1:0] cidx, tot_q, nb_q, nb_eff, nc_ext, tot_in;

  always_comb begin
    nb_eff = (byte_count == '0) ? TOT_W'(1) : TOT_W'(byte_count);
    nc_ext = TOT_W'(cycle_count);
    tot_in = ((nc_ext > nb_eff) ? nc_ext : nb_eff) + TOT_W'(extra_cycle);
  end

  assign real_fetch = cidx < nb_q;
  assign last_cycle = cidx == (tot_q - 1'b1);
  assign next_addr  = real_fetch ? fetch_addr + 1'b1 : fetch_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      fetch_addr <= '0;
      cidx       <= '0;
      tot_q      <= TOT_W'(1);
      nb_q       <= TOT_W'(1);
      done       <= 1'b0;
    end else begin
      done <= cyc_end && last_cycle;
      if (accept) begin
        busy       <= 1'b1;
        fetch_addr <= start_pc;
        cidx       <= '0;
        tot_q      <= tot_in;
        nb_q       <= nb_eff;
      end else if (cyc_end) begin
        fetch_addr <= next_addr;
        if (last_cycle) busy <= 1'b0;
        else            cidx <= cidx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfs_page_track.sv
module xfs_page_track #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_new
);
  logic page_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      page_ok  <= 1'b0;
      page_new <= 1'b0;
    end else if (load_en && (!page_ok || page_in != page_q)) begin
      page_q   <= page_in;
      page_ok  <= 1'b1;
      page_new <= 1'b1;
    end else begin
      page_new <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_code_fetcher.sv
module ext_code_fetcher
  import xfs_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int BYTE_W       = 2,
  parameter int CNT_W        = 3,
  parameter int CLKS_PER_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_valid,
  output logic                     start_ready,
  input  logic [ADDR_W-1:0]        start_pc,
  input  logic [BYTE_W-1:0]        byte_count,
  input  logic [CNT_W-1:0]         cycle_count,
  input  logic                     extra_cycle,
  output logic                     code_valid,
  output logic [DATA_W-1:0]        code_byte,
  output logic                     instr_done,
  output logic                     ale,
  output logic                     rd_n,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     hi_update,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  ph_role_e          role;
  logic              cyc_end, busy, real_fetch, last_cycle, accept, page_load;
  logic [ADDR_W-1:0] fetch_addr, next_addr;
  logic [PAGE_W-1:0] page_src;

  assign start_ready = !busy;
  assign accept      = start_valid && start_ready;

  xfs_phase_gen #(.CLKS(CLKS_PER_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(busy), .role(role), .cyc_end(cyc_end)
  );

  xfs_cycle_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_pc(start_pc),
    .byte_count(byte_count), .cycle_count(cycle_count), .extra_cycle(extra_cycle),
    .cyc_end(cyc_end), .busy(busy), .fetch_addr(fetch_addr), .real_fetch(real_fetch),
    .last_cycle(last_cycle), .next_addr(next_addr), .done(instr_done)
  );

  // Page register reloads at a start, or at the boundary into another cycle
  assign page_load = accept || (cyc_end && !last_cycle);
  assign page_src  = accept ? start_pc[ADDR_W-1:DATA_W] : next_addr[ADDR_W-1:DATA_W];

  xfs_page_track #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load_en(page_load), .page_in(page_src),
    .page_q(hi_addr), .page_new(hi_update)
  );

  // Bus strobes and shared port
  assign ale    = busy && (role == PH_ADDR);
  assign ad_oe  = busy && (role == PH_ADDR);
  assign rd_n   = !(busy && (role == PH_READ));
  assign ad_out = fetch_addr[DATA_W-1:0];

  // Capture on the edge closing the read phase; dummies are dropped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_byte  <= '0;
    end else begin
      code_valid <= cyc_end && real_fetch;
      if (cyc_end && real_fetch) code_byte <= ad_in;
    end
  end
endmodule

// File: rtl/xfs_checker.sv
module xfs_checker #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_valid,
  input logic            start_ready,
  input logic            code_valid,
  input logic            instr_done,
  input logic            ale,
  input logic            rd_n,
  input logic            ad_oe,
  input logic            hi_update,
  input logic [HI_W-1:0] hi_addr
);
  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && rd_n && !ad_oe));
  assert_read_after_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(ale, 2));
  assert_read_two_clocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);
  assert_port_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  assert_byte_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> !$past(rd_n));
  assert_page_at_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_update |-> ale);
  assert_page_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hi_addr) |-> ale);
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> start_ready);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);
endmodule

bind ext_code_fetcher xfs_checker #(.HI_W(ADDR_W - DATA_W)) u_xfs_checker (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .code_valid(code_valid), .instr_done(instr_done), .ale(ale), .rd_n(rd_n),
  .ad_oe(ad_oe), .hi_update(hi_update), .hi_addr(hi_addr)
);

// File: tb/ext_code_fetcher_tb.sv
`timescale 1ns/1ps
module ext_code_fetcher_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_valid, start_ready, extra_cycle;
  logic [15:0] start_pc;
  logic [1:0]  byte_count;
  logic [2:0]  cycle_count;
  logic        code_valid, instr_done, ale, rd_n, hi_update, ad_oe;
  logic [7:0]  code_byte, hi_addr, ad_out, ad_in;

  int errors = 0, checks = 0;
  bit finished = 0;
  bit first_fetch;
  logic [7:0] prev_page;

  always #2 clk = ~clk;

  ext_code_fetcher u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_pc(start_pc), .byte_count(byte_count), .cycle_count(cycle_count),
    .extra_cycle(extra_cycle), .code_valid(code_valid), .code_byte(code_byte),
    .instr_done(instr_done), .ale(ale), .rd_n(rd_n), .hi_addr(hi_addr),
    .hi_update(hi_update), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic int exp_total(input int nb, input int nc, input int ex);
    int b = (nb == 0) ? 1 : nb;
    return ((nc > b) ? nc : b) + ex;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " R9 ale"}, 16'(ale), 16'd0);
    check({tag, " R9 rd_n"}, 16'(rd_n), 16'd1);
    check({tag, " R9 ad_oe"}, 16'(ad_oe), 16'd0);
    check({tag, " R9 start_ready"}, 16'(start_ready), 16'd1);
    check({tag, " R9 code_valid"}, 16'(code_valid), 16'd0);
    check({tag, " R9 hi_update"}, 16'(hi_update), 16'd0);
  endtask

  // Called at a falling edge with the block idle
  task automatic run_instr(input logic [15:0] pc, input int nb, input int nc, input int ex);
    int tot, beff;
    tot  = exp_total(nb, nc, ex);
    beff = (nb == 0) ? 1 : nb;
    check("R8 ready before start", 16'(start_ready), 16'd1);
    start_valid = 1'b1; start_pc = pc; byte_count = 2'(nb);
    cycle_count = 3'(nc); extra_cycle = 1'(ex);
    for (int k = 0; k < 4 * tot; k++) begin
      int c, ph;
      logic [15:0] a;
      @(negedge clk);
      // Offers made while busy must be ignored (R8)
      start_valid = 1'($urandom);
      start_pc = 16'($urandom); byte_count = 2'($urandom);
      cycle_count = 3'($urandom); extra_cycle = 1'($urandom);
      c = k / 4; ph = k % 4;
      a = (c < beff) ? pc + 16'(c) : pc + 16'(beff);
      check("R1 ale", 16'(ale), 16'(ph == 0));
      check("R1 rd_n", 16'(rd_n), 16'(ph < 2));
      check("R2 ad_oe", 16'(ad_oe), 16'(ph == 0));
      if (ph == 0) check(c < beff ? "R6 ad_out" : "R7 ad_out dummy", 16'(ad_out), 16'(a[7:0]));
      check("R4 hi_addr", 16'(hi_addr), 16'(a[15:8]));
      if (ph == 0) begin
        check("R4 hi_update", 16'(hi_update), 16'(first_fetch || a[15:8] != prev_page));
        first_fetch = 1'b0; prev_page = a[15:8];
      end else check("R4 hi_update off", 16'(hi_update), 16'd0);
      check("R8 ready low", 16'(start_ready), 16'd0);
      check("R8 done low", 16'(instr_done), 16'd0);
      if (ph == 0 && c > 0 && (c - 1) < beff) begin
        check("R3 code_valid", 16'(code_valid), 16'd1);
        check("R6 code_byte", 16'(code_byte), 16'(mem_byte(pc + 16'(c - 1))));
      end else check("R7 R5 code_valid off", 16'(code_valid), 16'd0);
      ad_in = (ph >= 2) ? mem_byte(a) : 8'($urandom);
    end
    @(negedge clk);
    start_valid = 1'b0;
    check("R8 done pulse", 16'(instr_done), 16'd1);
    check("R8 ready back", 16'(start_ready), 16'd1);
    check("R5 no extra cycle ale", 16'(ale), 16'd0);
    check("R5 rd_n idle", 16'(rd_n), 16'd1);
    if (tot - 1 < beff) begin
      check("R3 last code_valid", 16'(code_valid), 16'd1);
      check("R6 last code_byte", 16'(code_byte), 16'(mem_byte(pc + 16'(tot - 1))));
    end else check("R7 last dummy no byte", 16'(code_valid), 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pc;
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_valid = 1'b0; start_pc = '0; byte_count = '0;
    cycle_count = '0; extra_cycle = 1'b0; ad_in = '0;
    first_fetch = 1'b1; prev_page = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_idle("reset");
    check("R9 done", 16'(instr_done), 16'd0);
    @(negedge clk);
    check_idle("idle");
    // Directed corners; first fetch lands on page 00 (R4 first-fetch reload)
    run_instr(16'h0010, 1, 1, 0);
    run_instr(16'h0011, 2, 2, 0);   // same page, no reload
    run_instr(16'h12FF, 3, 3, 0);   // page crossing inside instruction
    run_instr(16'h20FE, 2, 4, 0);   // dummies land on next page
    run_instr(16'h3000, 2, 2, 1);   // extra special-register cycle
    run_instr(16'h3100, 0, 0, 0);   // byte count 0 treated as 1
    run_instr(16'h3200, 3, 1, 0);   // cycle count below byte count
    run_instr(16'hFFFF, 2, 5, 1);   // address wraps
    run_instr(16'h0001, 1, 7, 1);   // longest run, many dummies
    // Constrained random: mostly sequential code, sometimes jumps
    pc = 16'h4000;
    for (int i = 0; i < 60; i++) begin
      int nb, nc, ex;
      nb = 1 + ($urandom % 3);
      nc = nb + ($urandom % 3);
      ex = ($urandom % 4 == 0) ? 1 : 0;
      if ($urandom % 5 == 0) pc = 16'($urandom);
      repeat ($urandom % 3) begin
        @(negedge clk);
        check_idle("gap");
      end
      run_instr(pc, nb, nc, ex);
      pc = pc + 16'(nb);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule